// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a processor-side word access to a byte-wide asynchronous memory. The memory sits behind a shared byte port and an external transparent address latch. A request gives a byte address, a 16-bit write word, a direction and a start pulse. The controller takes a snapshot of the request and drives the upper address bits on a dedicated port. It presents the middle address bits on the shared port while it pulses the latch-enable strobe. It then moves the word as two byte cycles, low byte first, and selects each byte with a separate address-bit pin.

Every strobe lasts one cycle plus a programmable number of wait states, so slower parts can be served. A value of zero gives the shortest access. Read bytes are collected into a high register and a low register. A busy flag tells software when both registers hold the new word.

The sequencer has five named states:
- IDLE waits for start.
- LATCH holds the latch-enable high with the address driven.
- LHOLD keeps the address on the port after the latch closes.
- STROBE asserts the read or write strobe.
- TAIL is a one-cycle recovery after each strobe.

The transitions are:
- IDLE→LATCH on an accepted start.
- LATCH→LHOLD after the pulse-width count.
- LHOLD→STROBE after the hold count.
- STROBE→TAIL after the wait-state count.
- TAIL→STROBE after the low byte.
- TAIL→IDLE after the high byte.

Top module: `ext_mem_bus_ctrl`

## Requirements
- R1: After reset, busy is 0, both strobes are high (inactive), latch-enable is 0, the shared port is not driven (oe 0, output 0) and both read-data registers are 0.
- R2: A start seen while idle captures address, write data, direction and wait count. Busy is 1 from the next cycle for exactly LE_CYC + HOLD_CYC + 2*(W+2) cycles, where W is the captured wait count.
- R3: Throughout a transfer, the dedicated port carries address bits 16..9 unchanged.
- R4: Address bits 8..1 are driven on the shared port with oe 1. This holds while latch-enable is high for LE_CYC cycles, and for HOLD_CYC further cycles after it falls.
- R5: Address bit 0 of the request is ignored. The byte-select pin is 0 for the first byte cycle and 1 for the second.
- R6: The two strobes are never low together, and neither is low while latch-enable is high.
- R7: Each strobe stays low for W+1 consecutive cycles. A change of the wait input during a transfer has no effect.
- R8: For a write, the shared port drives write-data bits 7..0 in the first byte cycle and bits 15..8 in the second. It drives them with oe 1 while the write strobe is low and for one cycle after.
- R9: For a read, oe is 0 from the first strobe cycle to the end of the transfer. The port is sampled on the last cycle of each read strobe: byte-select 0 goes to the low register and byte-select 1 to the high register. Both hold the new word when busy falls.
- R10: A start pulse while busy is ignored. The pin sequence and the results are those of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | 17 | Byte address of the word |
| req_wdata | input | 16 | Word to write |
| req_write | input | 1 | 1 write, 0 read |
| req_start | input | 1 | Start pulse |
| cfg_wait | input | WAIT_W | Wait states per strobe |
| busy | output | 1 | Transfer in progress |
| rd_data_hi | output | 8 | Byte read with byte-select 1 |
| rd_data_lo | output | 8 | Byte read with byte-select 0 |
| mem_ahi | output | 8 | Address bits 16..9 |
| mem_ad_out | output | 8 | Shared port output value |
| mem_ad_oe | output | 1 | Shared port output enable |
| mem_ad_in | input | 8 | Shared port input value |
| mem_le | output | 1 | Latch-enable strobe |
| mem_a0 | output | 1 | Byte-select address bit |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with WAIT_W=2, LE_CYC=2 and HOLD_CYC=1. With these values every wait count from 0 to 3 can be swept in both directions over several addresses, including misaligned ones. Each pin is compared in every cycle against a timeline that the bench computes from the phase lengths. A small latch-and-memory model returns read bytes as an arithmetic function of the latched address and the byte select. The bench pulses start in mid-transfer and changes the wait input at the same time.

// File: rtl/emb_pkg.sv
package emb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_LHOLD,
        ST_STROBE,
        ST_TAIL
    } emb_state_t;
endpackage

// File: rtl/emb_fsm.sv
module emb_fsm
    import emb_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int WAIT_W   = 4,
    parameter int LE_CYC   = 1,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_q,
    output emb_state_t        state,
    output logic              byte_sel,
    output logic              accept,
    output logic              last_strobe
);
    emb_state_t       nx_state;
    logic [CNT_W-1:0] cnt, nx_cnt;
    logic             nx_byte;
    logic             cnt_done;

    assign accept      = (state == ST_IDLE) && start;
    assign last_strobe = (state == ST_STROBE) && (cnt == CNT_W'(wait_q));

    always_comb begin
        cnt_done = 1'b0;
        unique case (state)
            ST_LATCH:  cnt_done = (cnt == CNT_W'(LE_CYC - 1));
            ST_LHOLD:  cnt_done = (cnt == CNT_W'(HOLD_CYC - 1));
            ST_STROBE: cnt_done = (cnt == CNT_W'(wait_q));
            default:   cnt_done = 1'b0;
        endcase
    end

    always_comb begin
        nx_state = state;
        nx_cnt   = cnt;
        nx_byte  = byte_sel;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nx_state = ST_LATCH;
                    nx_cnt   = '0;
                    nx_byte  = 1'b0;
                end
            end
            ST_LATCH, ST_LHOLD, ST_STROBE: begin
                if (cnt_done) begin
                    nx_cnt = '0;
                    unique case (state)
                        ST_LATCH:  nx_state = ST_LHOLD;
                        ST_LHOLD:  nx_state = ST_STROBE;
                        default:   nx_state = ST_TAIL;
                    endcase
                end else begin
                    nx_cnt = cnt + 1'b1;
                end
            end
            ST_TAIL: begin
                nx_cnt = '0;
                if (byte_sel) begin
                    nx_state = ST_IDLE;
                end else begin
                    nx_state = ST_STROBE;
                    nx_byte  = 1'b1;
                end
            end
            default: nx_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            byte_sel <= 1'b0;
        end else begin
            state    <= nx_state;
            cnt      <= nx_cnt;
            byte_sel <= nx_byte;
        end
    end

    // R2: an accepted start always opens the latch phase
    a_r2_start_to_latch: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_LATCH));

    // R10: a start during a transfer does not bring the sequencer back to the latch phase
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE) && start |=> (state != ST_LATCH));
endmodule

// File: rtl/emb_datapath.sv
module emb_datapath
    import emb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BYTE_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                last_strobe,
    input  logic                byte_sel,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*BYTE_W-1:0] req_wdata,
    input  logic                req_write,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic [BYTE_W-1:0]   mem_ad_in,
    output logic [ADDR_W-2:0]   addr_q,
    output logic                write_q,
    output logic [WAIT_W-1:0]   wait_q,
    output logic [BYTE_W-1:0]   wr_byte,
    output logic [BYTE_W-1:0]   rd_hi,
    output logic [BYTE_W-1:0]   rd_lo
);
    logic [2*BYTE_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            wait_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr[ADDR_W-1:1];
            wdata_q <= req_wdata;
            write_q <= req_write;
            wait_q  <= cfg_wait;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hi <= '0;
            rd_lo <= '0;
        end else if (last_strobe && !write_q) begin
            if (byte_sel) rd_hi <= mem_ad_in;
            else          rd_lo <= mem_ad_in;
        end
    end

    assign wr_byte = byte_sel ? wdata_q[2*BYTE_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];

    // R10: captured request is frozen while a strobe is in progress
    a_r10_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        last_strobe |=> $stable(addr_q) && $stable(wait_q));
endmodule

// File: rtl/emb_pins.sv
module emb_pins
    import emb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BYTE_W = 8,
    localparam int HI_W  = ADDR_W - 1 - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  emb_state_t        state,
    input  logic              byte_sel,
    input  logic              write_q,
    input  logic [ADDR_W-2:0] addr_q,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              busy,
    output logic [HI_W-1:0]   mem_ahi,
    output logic [BYTE_W-1:0] mem_ad_out,
    output logic              mem_ad_oe,
    output logic              mem_le,
    output logic              mem_a0,
    output logic              mem_rd_n,
    output logic              mem_wr_n
);
    always_comb begin
        busy       = 1'b1;
        mem_le     = 1'b0;
        mem_ad_oe  = 1'b0;
        mem_ad_out = '0;
        mem_rd_n   = 1'b1;
        mem_wr_n   = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_LATCH: begin
                mem_le     = 1'b1;
                mem_ad_oe  = 1'b1;
                mem_ad_out = addr_q[BYTE_W-1:0];
            end
            ST_LHOLD: begin
                mem_ad_oe  = 1'b1;
                mem_ad_out = addr_q[BYTE_W-1:0];
            end
            ST_STROBE: begin
                if (write_q) begin
                    mem_wr_n   = 1'b0;
                    mem_ad_oe  = 1'b1;
                    mem_ad_out = wr_byte;
                end else begin
                    mem_rd_n = 1'b0;
                end
            end
            ST_TAIL: begin
                if (write_q) begin
                    mem_ad_oe  = 1'b1;
                    mem_ad_out = wr_byte;
                end
            end
            default: busy = 1'b0;
        endcase
    end

    assign mem_ahi = addr_q[ADDR_W-2:BYTE_W];
    assign mem_a0  = byte_sel;

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    a_r6_no_strobe_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_le |-> (mem_rd_n && mem_wr_n));

    a_r9_read_port_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_ad_oe);

    a_r8_write_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> mem_ad_oe && $stable(mem_ad_out));

    a_r3_high_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mem_ahi));

    a_r5_second_byte_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_a0));
endmodule

// File: rtl/ext_mem_bus_ctrl.sv
module ext_mem_bus_ctrl
    import emb_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int BYTE_W   = 8,
    parameter int WAIT_W   = 4,
    parameter int LE_CYC   = 1,
    parameter int HOLD_CYC = 1,
    localparam int HI_W    = ADDR_W - 1 - BYTE_W,
    localparam int TMAX    = (LE_CYC > HOLD_CYC) ? LE_CYC : HOLD_CYC,
    localparam int TW      = $clog2(TMAX + 1),
    localparam int CNT_W   = (WAIT_W > TW) ? WAIT_W : TW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*BYTE_W-1:0] req_wdata,
    input  logic                req_write,
    input  logic                req_start,
    input  logic [WAIT_W-1:0]   cfg_wait,
    output logic                busy,
    output logic [BYTE_W-1:0]   rd_data_hi,
    output logic [BYTE_W-1:0]   rd_data_lo,
    output logic [HI_W-1:0]     mem_ahi,
    output logic [BYTE_W-1:0]   mem_ad_out,
    output logic                mem_ad_oe,
    input  logic [BYTE_W-1:0]   mem_ad_in,
    output logic                mem_le,
    output logic                mem_a0,
    output logic                mem_rd_n,
    output logic                mem_wr_n
);
    emb_state_t        state;
    logic              byte_sel, accept, last_strobe, write_q;
    logic [ADDR_W-2:0] addr_q;
    logic [WAIT_W-1:0] wait_q;
    logic [BYTE_W-1:0] wr_byte;

    emb_fsm #(
        .CNT_W(CNT_W), .WAIT_W(WAIT_W), .LE_CYC(LE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(req_start), .wait_q(wait_q),
        .state(state), .byte_sel(byte_sel), .accept(accept),
        .last_strobe(last_strobe)
    );

    emb_datapath #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WAIT_W(WAIT_W)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .last_strobe(last_strobe),
        .byte_sel(byte_sel), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .cfg_wait(cfg_wait), .mem_ad_in(mem_ad_in),
        .addr_q(addr_q), .write_q(write_q), .wait_q(wait_q),
        .wr_byte(wr_byte), .rd_hi(rd_data_hi), .rd_lo(rd_data_lo)
    );

    emb_pins #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .byte_sel(byte_sel),
        .write_q(write_q), .addr_q(addr_q), .wr_byte(wr_byte),
        .busy(busy), .mem_ahi(mem_ahi), .mem_ad_out(mem_ad_out),
        .mem_ad_oe(mem_ad_oe), .mem_le(mem_le), .mem_a0(mem_a0),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
    );
endmodule

// File: tb/ext_mem_bus_ctrl_test.sv
module ext_mem_bus_ctrl_test;
    localparam int WAIT_W = 2;
    localparam int LE_CYC = 2;
    localparam int HOLD_CYC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  cfg_wait = '0;
    logic        busy, mem_ad_oe, mem_le, mem_a0, mem_rd_n, mem_wr_n;
    logic [7:0]  rd_data_hi, rd_data_lo, mem_ahi, mem_ad_out, mem_ad_in;
    logic [7:0]  lat = '0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ext_mem_bus_ctrl #(.WAIT_W(WAIT_W), .LE_CYC(LE_CYC), .HOLD_CYC(HOLD_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_start(req_start), .cfg_wait(cfg_wait),
        .busy(busy), .rd_data_hi(rd_data_hi), .rd_data_lo(rd_data_lo),
        .mem_ahi(mem_ahi), .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe),
        .mem_ad_in(mem_ad_in), .mem_le(mem_le), .mem_a0(mem_a0),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
    );

    function automatic logic [7:0] mdl(input logic [7:0] hi, input logic [7:0] lo, input logic a0);
        return (hi * 8'd3) ^ lo ^ (a0 ? 8'hA5 : 8'h3C);
    endfunction

    always @(negedge clk) if (mem_le) lat <= mem_ad_out;
    assign mem_ad_in = !mem_rd_n ? mdl(mem_ahi, lat, mem_a0) : 8'hEE;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [16:0] a, input logic [15:0] wd, input logic wr,
                        input int w, input logic poke);
        int total;
        logic [7:0] b;
        logic [31:0] ev, av;
        total = LE_CYC + HOLD_CYC + 2 * (w + 2);
        req_addr = a; req_wdata = wd; req_write = wr; cfg_wait = 2'(w); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        for (int c = 0; c <= total; c++) begin
            logic le_e, oe_e, rd_e, wr_e, a0_e, bs_e;
            logic [7:0] ad_e;
            int off;
            le_e = 0; oe_e = 0; rd_e = 1; wr_e = 1; a0_e = 0; ad_e = 0; bs_e = (c < total);
            if (c < LE_CYC) begin
                le_e = 1; oe_e = 1; ad_e = a[8:1];
            end else if (c < LE_CYC + HOLD_CYC) begin
                oe_e = 1; ad_e = a[8:1];
            end else if (c < total) begin
                off = c - LE_CYC - HOLD_CYC;
                a0_e = (off >= w + 2);
                if (a0_e) off = off - (w + 2);
                b = a0_e ? wd[15:8] : wd[7:0];
                if (off <= w) begin
                    if (wr) begin wr_e = 0; oe_e = 1; ad_e = b; end
                    else rd_e = 0;
                end else if (wr) begin
                    oe_e = 1; ad_e = b;
                end
            end
            ev = {bs_e, le_e, oe_e, rd_e, wr_e, (c < total) ? a0_e : mem_a0, a[16:9], ad_e, 8'h00};
            av = {busy, mem_le, mem_ad_oe, mem_rd_n, mem_wr_n, mem_a0, mem_ahi, mem_ad_out, 8'h00};
            chk(av == ev, wr ? "R2 R3 R4 R5 R6 R7 R8 pins" : "R2 R3 R4 R5 R6 R7 R9 pins", av, ev);
            if (poke && c == 1) begin
                req_start = 1'b1; req_addr = ~a; req_write = ~wr; cfg_wait = 2'(w + 1);
            end
            if (poke && c == 2) req_start = 1'b0;
            if (c < total) @(negedge clk);
        end
        if (!wr) begin
            ev = {16'h0, mdl(a[16:9], a[8:1], 1'b1), mdl(a[16:9], a[8:1], 1'b0)};
            av = {16'h0, rd_data_hi, rd_data_lo};
            chk(av == ev, poke ? "R10 R9 read data" : "R9 read data", av, ev);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, mem_le, mem_ad_oe, mem_rd_n, mem_wr_n} == 5'b00011, "R1 reset pins",
            {busy, mem_le, mem_ad_oe, mem_rd_n, mem_wr_n}, 5'b00011);
        chk({rd_data_hi, rd_data_lo, mem_ad_out} == 24'h0, "R1 reset data",
            {rd_data_hi, rd_data_lo, mem_ad_out}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < 5; i++) begin
                logic [16:0] a;
                logic [15:0] d;
                a = 17'h12345 + 17'(i * 17'h09A27 + w * 17'h00311);
                d = 16'hC3A1 ^ 16'(i * 16'h1357 + w * 16'h0F0F);
                xfer(a, d, 1'b1, w, 1'b0);
                xfer(a, d, 1'b0, w, 1'b0);
            end
        end
        xfer(17'h1FFFF, 16'hBEEF, 1'b1, 0, 1'b1);
        xfer(17'h00001, 16'h0000, 1'b0, 3, 1'b1);
        xfer(17'h0AAAA, 16'h5A5A, 1'b0, 1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule